// File: doc/BRIEF.md
# Serial 001 Sequence Detector

This block watches a one-bit serial stream that is sampled on every rising clock edge and flags the moment the three most recent samples, oldest first, read 0, 0, 1. Two detectors run side by side on the same input. One has an output that depends on both its state and the live input. The other has an output that depends on its state alone.

The first detector has three states, held in a two-bit register. Its next-state and output logic are written as sum-of-products equations over the state bits and the input. It reports a match in the same cycle that the final 1 is presented. The second detector has four states and reports the same match from a dedicated state, so its flag appears exactly one cycle later. Comparing the two pins shows the latency cost of registering the detect decision.

The input is one bit that is sampled every cycle. There is no handshake and no back-pressure: each clock edge consumes one sample. A synchronous active-high reset returns both detectors to their idle state.

Top module: `pat001_detector`

## Requirements
- R1: While `rst` is high at a rising edge, both detectors return to idle. In the cycle after that edge, `match_mealy` and `match_moore` are 0. Samples taken before the reset do not count toward any later match.
- R2: `match_mealy` is 1 in a cycle when at least two samples have been taken since reset, the two most recent are 0 and 0, and `serial_in` is currently 1.
- R3: `match_mealy` is 0 in every other cycle. This includes a 1 that follows fewer than two zeros since reset.
- R4: `match_moore` is 1 for exactly one cycle, and that cycle immediately follows the edge that sampled the final 1 of a 0, 0, 1 run. It is 0 at every other time.
- R5: For any input stream, `match_moore` in cycle t+1 equals `match_mealy` in cycle t.
- R6: A run of more than two zeros followed by a 1 counts as one match. Back-to-back patterns such as 0,0,1,0,0,1 give two matches. A 1 that follows a match does not give a second match.
- R7: The three-state detector stores its states in two bits as idle=00, one zero=01 and two or more zeros=10. The code 11 is never held after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Serial sample, taken every rising edge |
| match_mealy | output | 1 | Same-cycle detect of 0,0,1 (state and input) |
| match_moore | output | 1 | Registered detect of 0,0,1, one cycle later (state only) |

## Verification
The assertions assume that `serial_in` is stable at every rising edge and holds a known value of 0 or 1. They also assume that `rst` is held for at least one edge before the stream starts. The stimulus changes the input only on falling edges and never drives X or Z. It applies reset first and again in mid-stream. It mixes long random streams, with zeros weighted high so that patterns appear often, with directed runs of repeated zeros, overlapping patterns and isolated ones.

// File: rtl/seq001_pkg.sv
package seq001_pkg;
  localparam int ST_W = 2;

  // Three-state detector codes; 2'b11 unused
  localparam logic [ST_W-1:0] ML_IDLE = 2'b00;
  localparam logic [ST_W-1:0] ML_ONE0 = 2'b01;
  localparam logic [ST_W-1:0] ML_TWO0 = 2'b10;
  localparam logic [ST_W-1:0] ML_BAD  = 2'b11;

  typedef enum logic [ST_W-1:0] {
    MR_IDLE = 2'b00,
    MR_ONE0 = 2'b01,
    MR_TWO0 = 2'b10,
    MR_HIT  = 2'b11
  } moore_st_e;
endpackage

// File: rtl/seq001_mealy.sv
module seq001_mealy
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  logic [ST_W-1:0] q;
  logic [ST_W-1:0] d;

  // Sum-of-products next-state; code 11 lands on 10 (din=0) or 00 (din=1)
  always_comb begin
    d[1] = (~din & q[0]) | (~din & q[1]);
    d[0] = ~q[1] & ~q[0] & ~din;
  end

  assign hit = q[1] & din;

  always_ff @(posedge clk) begin
    if (rst) q <= ML_IDLE;
    else     q <= d;
  end

  // R7: unused code never occupied
  p_legal_code_r7: assert property (@(posedge clk) disable iff (rst)
    q != ML_BAD);

  // R2: a hit needs the previous sample to be a zero
  p_hit_after_zero_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> !$past(din));

  // R3: leaving the two-zero state always goes through a 1 sample
  p_two0_exit_r3: assert property (@(posedge clk) disable iff (rst)
    (q == ML_TWO0) && din |=> q == ML_IDLE);
endmodule

// File: rtl/seq001_moore.sv
module seq001_moore
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  moore_st_e st, st_nx;

  always_comb begin
    unique case (st)
      MR_IDLE: st_nx = din ? MR_IDLE : MR_ONE0;
      MR_ONE0: st_nx = din ? MR_IDLE : MR_TWO0;
      MR_TWO0: st_nx = din ? MR_HIT  : MR_TWO0;
      MR_HIT:  st_nx = din ? MR_IDLE : MR_ONE0;
      default: st_nx = MR_IDLE;
    endcase
  end

  assign hit = (st == MR_HIT);

  always_ff @(posedge clk) begin
    if (rst) st <= MR_IDLE;
    else     st <= st_nx;
  end

  // R4: hit state only entered from two-zero state on a 1
  p_hit_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hit) |-> ($past(st) == MR_TWO0) && $past(din));

  // R4: hit lasts a single cycle
  p_hit_single_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
endmodule

// File: rtl/pat001_detector.sv
module pat001_detector
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  output logic match_mealy,
  output logic match_moore
);
  seq001_mealy u_mealy (
    .clk (clk),
    .rst (rst),
    .din (serial_in),
    .hit (match_mealy)
  );

  seq001_moore u_moore (
    .clk (clk),
    .rst (rst),
    .din (serial_in),
    .hit (match_moore)
  );

  // R5: registered detect trails the combinational one by one cycle
  p_lag_high_r5: assert property (@(posedge clk) disable iff (rst)
    match_mealy |=> match_moore);
  p_lag_low_r5: assert property (@(posedge clk) disable iff (rst)
    !match_mealy |=> !match_moore);
endmodule

// File: tb/sim_pat001_detector.sv
module sim_pat001_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b0;
  logic match_mealy, match_moore;

  int n_run = 0;
  int n_fail = 0;
  int n_mealy_hits = 0;
  bit done = 1'b0;

  logic [1:0] hist;
  int valid_cnt;
  bit prev_exp;

  always #10 clk = ~clk;

  pat001_detector u0 (
    .clk(clk), .rst(rst), .serial_in(serial_in),
    .match_mealy(match_mealy), .match_moore(match_moore)
  );

  function automatic bit exp_mealy(logic [1:0] h, int vc, bit b);
    return (vc >= 2) && (h == 2'b00) && b;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(int cycles);
    @(negedge clk);
    rst = 1'b1;
    serial_in = 1'b1;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    #5;
    chk("R1 mealy after reset", match_mealy, 1'b0);
    chk("R1 moore after reset", match_moore, 1'b0);
    rst = 1'b0;
    hist = 2'b11;
    valid_cnt = 0;
    prev_exp = 1'b0;
  endtask

  // drive one sample, check both outputs (R2/R3/R5 and R4 via prev)
  task automatic step(bit b, string tag);
    bit em;
    @(negedge clk);
    serial_in = b;
    #5;
    em = exp_mealy(hist, valid_cnt, b);
    if (em) n_mealy_hits++;
    chk(em ? {tag, " R2"} : {tag, " R3"}, match_mealy, em);
    chk({tag, " R4 R5"}, match_moore, prev_exp);
    @(posedge clk);
    hist = {hist[0], b};
    valid_cnt++;
    prev_exp = em;
  endtask

  task automatic seq(logic [15:0] bits, int len, string tag);
    for (int i = len - 1; i >= 0; i--) step(bits[i], tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0000_5eed);
    do_reset(3);
    // R3: a 1 right after reset is no match
    seq(16'b1, 1, "R3 early one");
    seq(16'b01, 2, "R3 single zero");
    // R2 basic
    seq(16'b001, 3, "R2 basic");
    seq(16'b0, 1, "R4 trailing");
    // R6: long zero run, overlap, repeated ones
    seq(16'b0000001, 7, "R6 long run");
    seq(16'b001001, 6, "R6 back to back");
    seq(16'b0011, 4, "R6 double one");
    seq(16'b0101010, 7, "R3 alternating");
    // R1: reset mid-pattern discards history
    seq(16'b00, 2, "R1 prefix");
    do_reset(1);
    seq(16'b1, 1, "R1 after mid reset");
    seq(16'b001, 3, "R1 resume");
    // random stream, zero-weighted
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 3) == 0, "R5 random");
      if (k == 1500) do_reset(2);
    end
    seq(16'b0, 1, "R5 tail");
    n_run++;
    if (n_mealy_hits < 20) begin
      n_fail++;
      $display("FAIL R2 coverage: actual %0d expected >=20 hits", n_mealy_hits);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule